// File: doc/BRIEF.md
# Programmable Master Video Timing Generator

This block is a free-running raster timing source in the pixel clock domain. It runs a horizontal position counter and a vertical line counter, both at zero at the leading edge of sync. From them it derives horizontal sync, vertical sync, a frame marker and a request/blanking strobe that tells an upstream pixel source when to supply the next line. A second strobe marks the clocks on which pixel data is expected, a programmable number of clocks after the request opens.

All timing values are held in a shadow set that is loaded from the inputs once after reset and then only at the boundary into each new frame. A frame is one odd field followed by one even field. The two fields have their own vertical offsets. Requests always open at the smaller of the two offsets, so the field with the larger offset requests extra leading lines. An optional table-load mode adds two request lines, of normal width, at the top of every field. The total line length and the number of lines per field come in as inputs. The field length itself is not set as a separate value.

Top module: `vid_tgen`

## Requirements
- R1: The horizontal sync active level lasts exactly 64 clocks from the first clock of each line. Its leading edges repeat every `line_len_i` clocks.
- R2: Vertical sync is active for exactly one whole line (line 0 of each field), and its leading edge falls on the same clock as a horizontal sync leading edge. Frame sync is active in the same line, but only in odd fields.
- R3: Polarity bit value 1 makes a sync output active high and value 0 makes it active low. `hs_pol_i` applies to `hs_o`; `vs_pol_i` applies to `vs_o` and `fs_o`.
- R4: On a requested line, `req_o` rises `h_off_i` clocks after the horizontal sync leading edge and stays high for `act_len_i` clocks.
- R5: On a requested line, `take_o` rises `data_dly_i` clocks after `req_o` rises and stays high for `act_len_i` clocks.
- R6: Counting line 0 as the vertical sync line, a field with offset V requests lines min(`voff_odd_i`,`voff_even_i`) through V+`act_lines_i`-1. No other line is requested unless R7 applies.
- R7: When `tbl_en_i` is 1, lines 0 and 1 of each field are also requested, with the same horizontal window as other lines. When it is 0 they are not requested and the other vertical timing is unchanged.
- R8: The first field after reset is odd (`odd_o`=1). The field toggles each time the line counter wraps after `fld_lines_i` lines.
- R9: Input changes take effect only from the start of the next odd field. The remainder of the current frame keeps the previous values.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_len_i | input | HW | Total clocks per line |
| fld_lines_i | input | VW | Lines per field |
| h_off_i | input | HW | Clocks from sync edge to request start |
| act_len_i | input | HW | Active clocks per line |
| data_dly_i | input | HW | Clocks from request start to first data |
| voff_odd_i | input | VW | First active line, odd field |
| voff_even_i | input | VW | First active line, even field |
| act_lines_i | input | VW | Active lines per field |
| tbl_en_i | input | 1 | Enable two table-load request lines |
| hs_pol_i | input | 1 | Horizontal sync polarity, 1 = active high |
| vs_pol_i | input | 1 | Vertical and frame sync polarity, 1 = active high |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| fs_o | output | 1 | Frame sync |
| req_o | output | 1 | Blanking / data request, active high |
| take_o | output | 1 | Data expected strobe |
| odd_o | output | 1 | Current field is odd |

## Verification
Two functions can land on the same clock. The first is the frame-boundary load of the shadow set. The second is the leading edge of vertical, horizontal and frame sync, which must use the new values from the very first clock of the frame. To provoke this, the request width and offset are changed in the middle of an odd field. The bench then checks that the following even field still shows the old window and that the next odd field shows the new window on every requested line. The same boundary is judged a second time where table-load lines 0 and 1 sit directly on the sync line. Their request pulses must match regular lines while vertical sync still covers line 0 alone.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int HSYNC_CLKS = 64;
  localparam int TBL_LINES  = 2;

  typedef enum logic {
    FLD_ODD  = 1'b0,
    FLD_EVEN = 1'b1
  } fld_e;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/vtg_hcnt.sv
module vtg_hcnt #(
  parameter int HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [HW-1:0] len_i,
  output logic [HW-1:0] h_o,
  output logic          wrap_o
);
  // compare h+1 against length so len 0 still wraps
  assign wrap_o = ({1'b0, h_o} + 1'b1) >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   h_o <= '0;
    else if (en_i) h_o <= wrap_o ? '0 : h_o + 1'b1;
  end
endmodule

// File: rtl/vtg_vcnt.sv
module vtg_vcnt
  import vtg_pkg::*;
#(
  parameter int VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          hwrap_i,
  input  logic [VW-1:0] lines_i,
  output logic [VW-1:0] v_o,
  output fld_e          fld_o,
  output logic          wrap_o
);
  assign wrap_o = ({1'b0, v_o} + 1'b1) >= {1'b0, lines_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= '0;
      fld_o <= FLD_ODD;
    end else if (en_i && hwrap_i) begin
      if (wrap_o) begin
        v_o   <= '0;
        fld_o <= (fld_o == FLD_ODD) ? FLD_EVEN : FLD_ODD;
      end else begin
        v_o   <= v_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtg_win.sv
module vtg_win
  import vtg_pkg::*;
#(
  parameter int HW     = 12,
  parameter int VW     = 10,
  parameter int HS_LEN = HSYNC_CLKS
) (
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          fld_odd_i,
  input  logic [HW-1:0] h_off_i,
  input  logic [HW-1:0] act_len_i,
  input  logic [HW-1:0] data_dly_i,
  input  logic [VW-1:0] voff_odd_i,
  input  logic [VW-1:0] voff_even_i,
  input  logic [VW-1:0] act_lines_i,
  input  logic          tbl_en_i,
  output logic          hs_o,
  output logic          vs_o,
  output logic          fs_o,
  output logic          req_o,
  output logic          take_o
);
  localparam int HX = HW + 2;
  localparam int VX = VW + 1;

  logic [HX-1:0] hx, req_lo, req_hi, tk_lo, tk_hi;
  logic [VW-1:0] vmin, vcur;
  logic [VX-1:0] vend;
  logic          tbl_line, body_line, line_req;

  assign hx     = HX'(h_i);
  assign req_lo = HX'(h_off_i);
  assign req_hi = req_lo + HX'(act_len_i);
  assign tk_lo  = req_lo + HX'(data_dly_i);
  assign tk_hi  = tk_lo + HX'(act_len_i);

  // requests open at the earlier field offset
  assign vmin = (voff_odd_i < voff_even_i) ? voff_odd_i : voff_even_i;
  assign vcur = fld_odd_i ? voff_odd_i : voff_even_i;
  assign vend = VX'(vcur) + VX'(act_lines_i);

  assign tbl_line  = tbl_en_i && (v_i < VW'(TBL_LINES));
  assign body_line = (v_i >= vmin) && (VX'(v_i) < vend);
  assign line_req  = tbl_line || body_line;

  assign hs_o   = hx < HX'(HS_LEN);
  assign vs_o   = (v_i == '0);
  assign fs_o   = vs_o && fld_odd_i;
  assign req_o  = line_req && (hx >= req_lo) && (hx < req_hi);
  assign take_o = line_req && (hx >= tk_lo) && (hx < tk_hi);
endmodule

// File: rtl/vid_tgen.sv
module vid_tgen
  import vtg_pkg::*;
#(
  parameter int HW     = 12,
  parameter int VW     = 10,
  parameter int HS_LEN = HSYNC_CLKS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] line_len_i,
  input  logic [VW-1:0] fld_lines_i,
  input  logic [HW-1:0] h_off_i,
  input  logic [HW-1:0] act_len_i,
  input  logic [HW-1:0] data_dly_i,
  input  logic [VW-1:0] voff_odd_i,
  input  logic [VW-1:0] voff_even_i,
  input  logic [VW-1:0] act_lines_i,
  input  logic          tbl_en_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  output logic          hs_o,
  output logic          vs_o,
  output logic          fs_o,
  output logic          req_o,
  output logic          take_o,
  output logic          odd_o
);
  localparam int CW = 4 * HW + 4 * VW + 3;
  localparam int NS = 3;

  logic          first_q, run, ld;
  logic [CW-1:0] cfg_d, cfg_q;

  logic [HW-1:0] s_line_len, s_h_off, s_act_len, s_dly;
  logic [VW-1:0] s_fld_lines, s_voff_odd, s_voff_even, s_act_lines;
  logic          s_tbl, s_hs_pol, s_vs_pol;

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  fld_e          fld;
  logic          hwrap, vwrap, fld_odd;
  logic          hs_c, vs_c, fs_c, req_c, take_c;

  logic          hs_act_q, vs_act_q, fs_act_q;
  logic [NS-1:0] sync_act, sync_pol, sync_q;

  // first cycle after reset only loads the shadow set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b1;
    else         first_q <= 1'b0;
  end

  assign run     = !first_q;
  assign fld_odd = (fld == FLD_ODD);
  assign ld      = first_q || (run && hwrap && vwrap && !fld_odd);

  assign cfg_d = {line_len_i, h_off_i, act_len_i, data_dly_i,
                  fld_lines_i, voff_odd_i, voff_even_i, act_lines_i,
                  tbl_en_i, hs_pol_i, vs_pol_i};
  assign {s_line_len, s_h_off, s_act_len, s_dly,
          s_fld_lines, s_voff_odd, s_voff_even, s_act_lines,
          s_tbl, s_hs_pol, s_vs_pol} = cfg_q;

  vtg_shadow #(.W(CW)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld),
    .d_i   (cfg_d),
    .q_o   (cfg_q)
  );

  vtg_hcnt #(.HW(HW)) u_hcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .len_i (s_line_len),
    .h_o   (h),
    .wrap_o(hwrap)
  );

  vtg_vcnt #(.VW(VW)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .hwrap_i(hwrap),
    .lines_i(s_fld_lines),
    .v_o    (v),
    .fld_o  (fld),
    .wrap_o (vwrap)
  );

  vtg_win #(.HW(HW), .VW(VW), .HS_LEN(HS_LEN)) u_win (
    .h_i        (h),
    .v_i        (v),
    .fld_odd_i  (fld_odd),
    .h_off_i    (s_h_off),
    .act_len_i  (s_act_len),
    .data_dly_i (s_dly),
    .voff_odd_i (s_voff_odd),
    .voff_even_i(s_voff_even),
    .act_lines_i(s_act_lines),
    .tbl_en_i   (s_tbl),
    .hs_o       (hs_c),
    .vs_o       (vs_c),
    .fs_o       (fs_c),
    .req_o      (req_c),
    .take_o     (take_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_act_q <= 1'b0;
      vs_act_q <= 1'b0;
      fs_act_q <= 1'b0;
      req_o    <= 1'b0;
      take_o   <= 1'b0;
      odd_o    <= 1'b0;
    end else if (run) begin
      hs_act_q <= hs_c;
      vs_act_q <= vs_c;
      fs_act_q <= fs_c;
      req_o    <= req_c;
      take_o   <= take_c;
      odd_o    <= fld_odd;
    end
  end

  assign sync_act = {fs_c, vs_c, hs_c};
  assign sync_pol = {s_vs_pol, s_vs_pol, s_hs_pol};

  for (genvar i = 0; i < NS; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  sync_q[i] <= 1'b0;
      else if (run) sync_q[i] <= sync_pol[i] ? sync_act[i] : !sync_act[i];
    end
  end

  assign hs_o = sync_q[0];
  assign vs_o = sync_q[1];
  assign fs_o = sync_q[2];
endmodule

// File: rtl/vid_tgen_chk.sv
module vid_tgen_chk #(
  parameter int HW     = 12,
  parameter int HS_LEN = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hs_act,
  input logic          vs_act,
  input logic          fs_act,
  input logic [HW-1:0] line_len
);
  logic [HW:0] hs_run_q, vs_run_q;
  logic        fs_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_run_q  <= '0;
      vs_run_q  <= '0;
      fs_last_q <= 1'b0;
    end else begin
      hs_run_q <= hs_act ? hs_run_q + 1'b1 : '0;
      vs_run_q <= vs_act ? vs_run_q + 1'b1 : '0;
      if (vs_act && !vs_run_q[0] && vs_run_q == '0) fs_last_q <= fs_act;
    end
  end

  AST_HS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_act) |-> (hs_run_q == (HW+1)'(HS_LEN)));  // R1
  AST_VS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vs_act) |-> (vs_run_q == {1'b0, line_len}));  // R2
  AST_VS_HS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_act) |-> $rose(hs_act));  // R2
  AST_FS_IN_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_act |-> vs_act);  // R2
  AST_FS_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_act) |-> (fs_act != fs_last_q));  // R8
endmodule

bind vid_tgen vid_tgen_chk #(.HW(HW), .HS_LEN(HS_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hs_act  (hs_act_q),
  .vs_act  (vs_act_q),
  .fs_act  (fs_act_q),
  .line_len(s_line_len)
);

// File: tb/vid_tgen_test.sv
module vid_tgen_test;
  localparam int HW = 12;
  localparam int VW = 10;
  localparam int LL = 100;
  localparam int FL = 12;
  localparam int HSL = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [HW-1:0] line_len_i = HW'(LL);
  logic [VW-1:0] fld_lines_i = VW'(FL);
  logic [HW-1:0] h_off_i = '0, act_len_i = '0, data_dly_i = '0;
  logic [VW-1:0] voff_odd_i = '0, voff_even_i = '0, act_lines_i = '0;
  logic          tbl_en_i = 1'b0, hs_pol_i = 1'b1, vs_pol_i = 1'b1;
  logic          hs_o, vs_o, fs_o, req_o, take_o, odd_o;

  int n_chk = 0, n_err = 0;

  int req_first[FL], req_cnt[FL], take_first[FL], take_cnt[FL];
  int hs_first[FL], hs_cnt[FL];
  int vs_cnt, fs_cnt, odd_at0;
  logic raw_hs0, raw_vs_idle;

  always #2.5 clk_i = ~clk_i;

  vid_tgen #(.HW(HW), .VW(VW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .line_len_i(line_len_i), .fld_lines_i(fld_lines_i),
    .h_off_i(h_off_i), .act_len_i(act_len_i), .data_dly_i(data_dly_i),
    .voff_odd_i(voff_odd_i), .voff_even_i(voff_even_i), .act_lines_i(act_lines_i),
    .tbl_en_i(tbl_en_i), .hs_pol_i(hs_pol_i), .vs_pol_i(vs_pol_i),
    .hs_o(hs_o), .vs_o(vs_o), .fs_o(fs_o), .req_o(req_o), .take_o(take_o),
    .odd_o(odd_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int hoff, input int alen, input int dly,
                     input int vo, input int ve, input int al, input bit tbl,
                     input bit hp, input bit vp);
    h_off_i = HW'(hoff); act_len_i = HW'(alen); data_dly_i = HW'(dly);
    voff_odd_i = VW'(vo); voff_even_i = VW'(ve); act_lines_i = VW'(al);
    tbl_en_i = tbl; hs_pol_i = hp; vs_pol_i = vp;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_vs_rise();
    logic prv, cur;
    prv = (vs_o == vs_pol_i);
    while (1) begin
      @(negedge clk_i);
      cur = (vs_o == vs_pol_i);
      if (cur && !prv) break;
      prv = cur;
    end
  endtask

  // records one field; fresh=1 uses the current sample as clock 0
  task automatic measure(input bit fresh, input int chg_t);
    for (int l = 0; l < FL; l++) begin
      req_first[l] = -1; req_cnt[l] = 0; take_first[l] = -1; take_cnt[l] = 0;
      hs_first[l] = -1; hs_cnt[l] = 0;
    end
    vs_cnt = 0; fs_cnt = 0;
    for (int t = 0; t < FL * LL; t++) begin
      int l, hp;
      if (t > 0 || !fresh) @(negedge clk_i);
      l = t / LL; hp = t % LL;
      if (t == 0) begin odd_at0 = int'(odd_o); raw_hs0 = hs_o; end
      if (t == LL + 1) raw_vs_idle = vs_o;
      if (hs_o == hs_pol_i) begin hs_cnt[l]++; if (hs_first[l] < 0) hs_first[l] = hp; end
      if (req_o) begin req_cnt[l]++; if (req_first[l] < 0) req_first[l] = hp; end
      if (take_o) begin take_cnt[l]++; if (take_first[l] < 0) take_first[l] = hp; end
      if (vs_o == vs_pol_i) vs_cnt++;
      if (fs_o == vs_pol_i) fs_cnt++;
      if (t == chg_t) begin act_len_i = HW'(10); h_off_i = HW'(75); end
    end
  endtask

  task automatic check_field(input bit exp_odd, input int vlo, input int vhi,
                             input bit tbl, input int hoff, input int alen, input int dly);
    chk(odd_at0 == int'(exp_odd), "R8 field identity", odd_at0, int'(exp_odd));
    chk(vs_cnt == LL, "R2 vsync width", vs_cnt, LL);
    chk(fs_cnt == (exp_odd ? LL : 0), "R2 frame sync", fs_cnt, exp_odd ? LL : 0);
    for (int l = 0; l < FL; l++) begin
      bit rq;
      rq = (tbl && l < 2) || (l >= vlo && l <= vhi);
      chk(hs_first[l] == 0 && hs_cnt[l] == HSL, "R1 hsync", hs_cnt[l], HSL);
      if (rq) begin
        chk(req_first[l] == hoff, (l < 2 && tbl) ? "R7 table req start" : "R4 req start",
            req_first[l], hoff);
        chk(req_cnt[l] == alen, "R4 req length", req_cnt[l], alen);
        chk(take_first[l] == hoff + dly, "R5 data start", take_first[l], hoff + dly);
        chk(take_cnt[l] == alen, "R5 data length", take_cnt[l], alen);
      end else begin
        chk(req_cnt[l] == 0, (l < 2) ? "R7 no table req" : "R6 line not requested",
            req_cnt[l], 0);
        chk(take_cnt[l] == 0, "R6 no data on idle line", take_cnt[l], 0);
      end
    end
  endtask

  task automatic t_reset();
    cfg(70, 20, 4, 3, 3, 4, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk({hs_o, vs_o, fs_o, req_o, take_o, odd_o} == 6'b0, "R10 reset outputs",
        int'({hs_o, vs_o, fs_o, req_o, take_o, odd_o}), 0);
  endtask

  task automatic t_base();
    cfg(70, 20, 4, 3, 3, 4, 1'b0, 1'b1, 1'b1);
    do_reset();
    wait_vs_rise();
    measure(1'b1, -1);
    check_field(1'b1, 3, 6, 1'b0, 70, 20, 4);
    measure(1'b0, -1);
    check_field(1'b0, 3, 6, 1'b0, 70, 20, 4);
  endtask

  task automatic t_polarity();
    cfg(70, 20, 4, 3, 3, 4, 1'b0, 1'b0, 1'b0);
    do_reset();
    wait_vs_rise();   // active-low vsync: first detectable edge opens the even field
    measure(1'b1, -1);
    chk(raw_hs0 == 1'b0, "R3 hsync active low", int'(raw_hs0), 0);
    chk(raw_vs_idle == 1'b1, "R3 vsync idle high", int'(raw_vs_idle), 1);
    check_field(1'b0, 3, 6, 1'b0, 70, 20, 4);
    measure(1'b0, -1);
    check_field(1'b1, 3, 6, 1'b0, 70, 20, 4);
  endtask

  task automatic t_split();
    cfg(70, 20, 4, 3, 5, 4, 1'b0, 1'b1, 1'b1);
    do_reset();
    wait_vs_rise();
    measure(1'b1, -1);
    check_field(1'b1, 3, 6, 1'b0, 70, 20, 4);   // R6 odd: 4 lines
    measure(1'b0, -1);
    check_field(1'b0, 3, 8, 1'b0, 70, 20, 4);   // R6 even: 4+2 lines
  endtask

  task automatic t_table();
    cfg(66, 24, 6, 2, 2, 4, 1'b1, 1'b1, 1'b1);
    do_reset();
    wait_vs_rise();
    measure(1'b1, -1);
    check_field(1'b1, 2, 5, 1'b1, 66, 24, 6);   // R7 on
    cfg(66, 24, 6, 2, 2, 4, 1'b0, 1'b1, 1'b1);
    do_reset();
    wait_vs_rise();
    measure(1'b1, -1);
    check_field(1'b1, 2, 5, 1'b0, 66, 24, 6);   // R7 off
  endtask

  task automatic t_update();
    cfg(70, 20, 4, 3, 3, 4, 1'b0, 1'b1, 1'b1);
    do_reset();
    wait_vs_rise();
    measure(1'b1, 250);                         // R9 change mid odd field
    check_field(1'b1, 3, 6, 1'b0, 70, 20, 4);
    measure(1'b0, -1);
    check_field(1'b0, 3, 6, 1'b0, 70, 20, 4);   // R9 even keeps old
    measure(1'b0, -1);
    check_field(1'b1, 3, 6, 1'b0, 75, 10, 4);   // R9 next frame new
  endtask

  initial begin
    t_reset();
    t_base();
    t_polarity();
    t_split();
    t_table();
    t_update();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule